// File: doc/BRIEF.md
# Speculative Task Commit Controller

This block sequences speculative tasks that run on a group of processors. Task numbers are handed out in rotation: at the start of a speculative region processor p runs task p, and a processor that retires its task with an advancing commit takes the number NPROC higher. The processor whose task number equals the oldest outstanding number (the head) holds the non-speculative state. Only that processor may commit. Commit requests from any other processor are held off until ownership reaches it.

The controller also guards against read-after-write ordering errors. For each processor it keeps one read bit per tracked address slot. A checked (non-sync) write to a slot that a younger task has already read squashes the oldest such reader. Every task younger than that reader is squashed as well. The affected processors receive a one-cycle flush/restart pulse. Sync writes skip this check. A terminate request from the owner closes the speculative region and flushes all the other processors. Task order is judged by each task number's distance from the head, so the task-number counters may wrap freely. The data state of each processor is kept elsewhere.

Top module: `stc_commit_ctrl`

## Requirements
- R1: After synchronous reset, spec_active_o, grant_o and flush_o are all zero, and every field of task_id_o is zero.
- R2: A spec_start_i pulse while inactive sets spec_active_o at the next edge and loads task number p into processor p, which makes processor 0 the owner. A pulse while already active changes nothing.
- R3: While active, grant_o[p] is asserted in the same cycle as cmt_req_i[p], adv_req_i[p] or term_req_i[p], but only if processor p holds the head task number. Requests from other processors get no grant. While inactive, no grant is given.
- R4: A granted advancing commit adds NPROC (modulo 2^TID_W) to that processor's task number at the edge. Ownership then moves to the processor holding head+1, which is the next processor index modulo NPROC.
- R5: A granted plain commit leaves every task number and the ownership unchanged.
- R6: While active, rd_vld_i[p] records a read by processor p of slot rd_addr_i[p*ADDR_W +: ADDR_W] at the edge.
- R7: While active, a checked write by processor w to slot s finds the lowest-numbered task that is younger than w's task and that recorded a read of s at an earlier edge. Starting one edge after the write, flush_o is high for one cycle on the processor running that task and on every processor running a younger task. Reads by older tasks, by w itself, or in the same cycle as the write cause no flush.
- R8: A write with wr_sync_i[w] set never causes a flush.
- R9: A processor's read bits are cleared when it is flushed or when its commit is granted. A later write to a slot it read before then does not flush it.
- R10: A granted terminate clears spec_active_o at the edge. flush_o is then high for one cycle on every processor except the terminating one. All read bits are cleared and task numbers are kept.
- R11: When the owner raises several requests at once, terminate takes precedence over advancing commit, and advancing commit takes precedence over plain commit.
- R12: Ordering and violation detection stay correct after task numbers wrap past 2^TID_W - 1.
- R13: While inactive, reads, writes and commit requests have no effect: no grant, no flush, and no recorded reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spec_start_i | input | 1 | Opens a speculative region |
| rd_vld_i | input | NPROC | Read valid, bit p for processor p |
| rd_addr_i | input | NPROC*ADDR_W | Read slot, field p for processor p |
| wr_vld_i | input | NPROC | Write valid, bit p for processor p |
| wr_sync_i | input | NPROC | Marks the write as a sync write (unchecked) |
| wr_addr_i | input | NPROC*ADDR_W | Write slot, field p for processor p |
| cmt_req_i | input | NPROC | Plain commit request |
| adv_req_i | input | NPROC | Commit-and-advance request |
| term_req_i | input | NPROC | Terminate request |
| grant_o | output | NPROC | Commit grant, same cycle as the request |
| flush_o | output | NPROC | One-cycle flush/restart pulse |
| spec_active_o | output | 1 | Speculative region open |
| task_id_o | output | NPROC*TID_W | Task number held by each processor |

## Verification
Grants are combinational, so the bench compares grant_o one time unit after driving the requests, before the edge that acts on them. Flush pulses, the active flag and task numbers change at the edge that samples the request or write. The bench compares them at the falling edge that follows. A behavioural model keeps unbounded integer task numbers and per-processor read sets, advances at every rising edge, and is checked against the outputs at both sampling points in every cycle. Directed sequences add explicit checks for the squash masks, sync writes, clearing on commit, terminate and wrap-around.

// File: rtl/stc_pkg.sv
package stc_pkg;

    // Action taken for the owning processor in one cycle
    typedef enum logic [1:0] {
        OP_NONE,
        OP_COMMIT,
        OP_ADVANCE,
        OP_TERMINATE
    } owner_op_e;

    // Terminate wins over advance, advance wins over plain commit (R11)
    function automatic owner_op_e pick_op(input logic cmt, input logic adv, input logic term);
        if (term)
            return OP_TERMINATE;
        else if (adv)
            return OP_ADVANCE;
        else if (cmt)
            return OP_COMMIT;
        return OP_NONE;
    endfunction

endpackage

// File: rtl/stc_order.sv
module stc_order
    import stc_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int TID_W = 8,
    parameter int PW    = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic [NPROC-1:0]       cmt_i,
    input  logic [NPROC-1:0]       adv_i,
    input  logic [NPROC-1:0]       term_i,
    output logic                   active_o,
    output logic [NPROC-1:0]       owner_o,
    output logic [NPROC-1:0]       grant_o,
    output logic [NPROC*PW-1:0]    rel_o,
    output logic                   term_fire_o,
    output logic [NPROC*TID_W-1:0] tid_o
);

    logic [TID_W-1:0] tid_q [NPROC];
    logic [TID_W-1:0] head_id_q;
    logic [PW-1:0]    head_q;
    logic             active_q;
    owner_op_e        op;

    // Distance of each task from the head; wraps together with the counters
    always_comb begin
        for (int p = 0; p < NPROC; p++) begin
            logic [TID_W-1:0] diff;
            diff                = tid_q[p] - head_id_q;
            rel_o[p*PW +: PW]   = diff[PW-1:0];
            owner_o[p]          = active_q && (diff == '0);
        end
    end

    assign grant_o     = owner_o & (cmt_i | adv_i | term_i);
    assign op          = pick_op(|(grant_o & cmt_i), |(grant_o & adv_i), |(grant_o & term_i));
    assign term_fire_o = (op == OP_TERMINATE);
    assign active_o    = active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q  <= 1'b0;
            head_id_q <= '0;
            head_q    <= '0;
            for (int p = 0; p < NPROC; p++)
                tid_q[p] <= '0;
        end else if (!active_q) begin
            if (start_i) begin
                active_q  <= 1'b1;
                head_id_q <= '0;
                head_q    <= '0;
                for (int p = 0; p < NPROC; p++)
                    tid_q[p] <= TID_W'(p);
            end
        end else begin
            case (op)
                OP_ADVANCE: begin
                    tid_q[head_q] <= tid_q[head_q] + TID_W'(NPROC);
                    head_id_q     <= head_id_q + 1'b1;
                    head_q        <= (head_q == PW'(NPROC-1)) ? '0 : head_q + 1'b1;
                end
                OP_TERMINATE: active_q <= 1'b0;
                default: ;
            endcase
        end
    end

    generate
        for (genvar g = 0; g < NPROC; g++) begin : g_tid_out
            assign tid_o[g*TID_W +: TID_W] = tid_q[g];
        end
    endgenerate

    // R3
    one_owner_chk: assert property (@(posedge clk) disable iff (rst)
        active_q |-> ($countones(owner_o) == 1) && owner_o[head_q]);

    // R4
    adv_moves_head_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADVANCE) |=> (head_id_q == $past(head_id_q) + 1'b1));

    // R10
    term_ends_chk: assert property (@(posedge clk) disable iff (rst)
        term_fire_o |=> !active_q);

endmodule

// File: rtl/stc_readset.sv
module stc_readset #(
    parameter int NPROC = 4,
    parameter int NSLOT = 16,
    parameter int PW    = 2,
    parameter int AW    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                active_i,
    input  logic [NPROC-1:0]    owner_i,
    input  logic [NPROC*PW-1:0] rel_i,
    input  logic [NPROC-1:0]    rd_vld_i,
    input  logic [NPROC*AW-1:0] rd_addr_i,
    input  logic [NPROC-1:0]    wr_vld_i,
    input  logic [NPROC-1:0]    wr_sync_i,
    input  logic [NPROC*AW-1:0] wr_addr_i,
    input  logic [NPROC-1:0]    clr_i,
    input  logic                wipe_i,
    output logic [NPROC-1:0]    viol_o
);

    logic [NSLOT-1:0] rbits_q [NPROC];
    logic             any_bits;

    // For each checked write: oldest younger reader, then every task from it on
    always_comb begin
        viol_o = '0;
        for (int w = 0; w < NPROC; w++) begin
            logic          found;
            logic [PW-1:0] best;
            logic [PW-1:0] rw;
            logic [AW-1:0] wa;
            found = 1'b0;
            best  = '1;
            rw    = rel_i[w*PW +: PW];
            wa    = wr_addr_i[w*AW +: AW];
            if (active_i && wr_vld_i[w] && !wr_sync_i[w]) begin
                for (int q = 0; q < NPROC; q++) begin
                    if (rbits_q[q][wa] && (rel_i[q*PW +: PW] > rw) &&
                        (!found || (rel_i[q*PW +: PW] < best))) begin
                        found = 1'b1;
                        best  = rel_i[q*PW +: PW];
                    end
                end
                for (int q = 0; q < NPROC; q++)
                    if (found && (rel_i[q*PW +: PW] >= best))
                        viol_o[q] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || wipe_i) begin
            for (int q = 0; q < NPROC; q++)
                rbits_q[q] <= '0;
        end else begin
            for (int q = 0; q < NPROC; q++) begin
                if (clr_i[q] || viol_o[q])
                    rbits_q[q] <= '0;
                else if (active_i && rd_vld_i[q])
                    rbits_q[q][rd_addr_i[q*AW +: AW]] <= 1'b1;
            end
        end
    end

    always_comb begin
        any_bits = 1'b0;
        for (int q = 0; q < NPROC; q++)
            any_bits = any_bits | (|rbits_q[q]);
    end

    // R7
    owner_never_flushed_chk: assert property (@(posedge clk) disable iff (rst)
        (viol_o & owner_i) == '0);

    // R13
    idle_bits_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !active_i |-> !any_bits);

    generate
        for (genvar g = 0; g < NPROC; g++) begin : g_row_chk
            // R9
            flushed_row_clear_chk: assert property (@(posedge clk) disable iff (rst)
                viol_o[g] |=> (rbits_q[g] == '0));
        end
    endgenerate

endmodule

// File: rtl/stc_commit_ctrl.sv
module stc_commit_ctrl #(
    parameter int NPROC = 4,
    parameter int NSLOT = 16,
    parameter int TID_W = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              spec_start_i,
    input  logic [NPROC-1:0]                  rd_vld_i,
    input  logic [NPROC*$clog2(NSLOT)-1:0]    rd_addr_i,
    input  logic [NPROC-1:0]                  wr_vld_i,
    input  logic [NPROC-1:0]                  wr_sync_i,
    input  logic [NPROC*$clog2(NSLOT)-1:0]    wr_addr_i,
    input  logic [NPROC-1:0]                  cmt_req_i,
    input  logic [NPROC-1:0]                  adv_req_i,
    input  logic [NPROC-1:0]                  term_req_i,
    output logic [NPROC-1:0]                  grant_o,
    output logic [NPROC-1:0]                  flush_o,
    output logic                              spec_active_o,
    output logic [NPROC*TID_W-1:0]            task_id_o
);

    localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1;
    localparam int AW = $clog2(NSLOT);

    logic [NPROC-1:0]    owner;
    logic [NPROC*PW-1:0] rel;
    logic                term_fire;
    logic [NPROC-1:0]    viol;
    logic [NPROC-1:0]    flush_d;
    logic [NPROC-1:0]    flush_q;

    stc_order #(.NPROC(NPROC), .TID_W(TID_W), .PW(PW)) u_order (
        .clk        (clk),
        .rst        (rst),
        .start_i    (spec_start_i),
        .cmt_i      (cmt_req_i),
        .adv_i      (adv_req_i),
        .term_i     (term_req_i),
        .active_o   (spec_active_o),
        .owner_o    (owner),
        .grant_o    (grant_o),
        .rel_o      (rel),
        .term_fire_o(term_fire),
        .tid_o      (task_id_o)
    );

    stc_readset #(.NPROC(NPROC), .NSLOT(NSLOT), .PW(PW), .AW(AW)) u_readset (
        .clk      (clk),
        .rst      (rst),
        .active_i (spec_active_o),
        .owner_i  (owner),
        .rel_i    (rel),
        .rd_vld_i (rd_vld_i),
        .rd_addr_i(rd_addr_i),
        .wr_vld_i (wr_vld_i),
        .wr_sync_i(wr_sync_i),
        .wr_addr_i(wr_addr_i),
        .clr_i    (grant_o),
        .wipe_i   (term_fire),
        .viol_o   (viol)
    );

    // Terminate squashes everyone but the terminating owner
    assign flush_d = viol | (term_fire ? ~grant_o : '0);

    always_ff @(posedge clk) begin
        if (rst)
            flush_q <= '0;
        else
            flush_q <= flush_d;
    end

    assign flush_o = flush_q;

    // R10
    term_flush_chk: assert property (@(posedge clk) disable iff (rst)
        term_fire |=> (flush_o == ~$past(grant_o)));

endmodule

// File: tb/stc_commit_ctrl_test.sv
`timescale 1ns/100ps
module stc_commit_ctrl_test;

    localparam int NP = 4;
    localparam int NS = 16;
    localparam int TW = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [NP-1:0]  rd_vld = '0, wr_vld = '0, wr_sync = '0;
    logic [NP*4-1:0] rd_addr = '0, wr_addr = '0;
    logic [NP-1:0]  cmt = '0, adv = '0, term = '0;
    logic [NP-1:0]  grant, flush;
    logic           active;
    logic [NP*TW-1:0] tids;

    int vectors = 0;
    int miscompares = 0;

    // behavioural reference state
    int m_tid [NP];
    int m_head = 0;
    bit m_act = 0;
    bit m_bits [NP][NS];
    bit [NP-1:0] m_flush = '0;

    always #2.5 clk = ~clk;

    stc_commit_ctrl #(.NPROC(NP), .NSLOT(NS), .TID_W(TW)) uut (
        .clk(clk), .rst(rst), .spec_start_i(start),
        .rd_vld_i(rd_vld), .rd_addr_i(rd_addr),
        .wr_vld_i(wr_vld), .wr_sync_i(wr_sync), .wr_addr_i(wr_addr),
        .cmt_req_i(cmt), .adv_req_i(adv), .term_req_i(term),
        .grant_o(grant), .flush_o(flush), .spec_active_o(active), .task_id_o(tids)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int owner_of();
        for (int p = 0; p < NP; p++)
            if (m_tid[p] == m_head) return p;
        return -1;
    endfunction

    function automatic logic [NP-1:0] exp_grant();
        logic [NP-1:0] g = '0;
        int o;
        if (m_act) begin
            o = owner_of();
            if (o >= 0 && (cmt[o] | adv[o] | term[o])) g[o] = 1'b1;
        end
        return g;
    endfunction

    task automatic model_update();
        bit [NP-1:0] fl = '0;
        int o;
        bit g;
        if (rst) begin
            m_act = 0; m_head = 0; m_flush = '0;
            for (int p = 0; p < NP; p++) begin
                m_tid[p] = 0;
                for (int s = 0; s < NS; s++) m_bits[p][s] = 0;
            end
            return;
        end
        if (!m_act) begin
            if (start) begin
                m_act = 1; m_head = 0;
                for (int p = 0; p < NP; p++) m_tid[p] = p;
            end
            m_flush = '0;
            return;
        end
        o = owner_of();
        g = cmt[o] | adv[o] | term[o];
        for (int w = 0; w < NP; w++) begin
            if (wr_vld[w] && !wr_sync[w]) begin
                int best = -1;
                int a = int'(wr_addr[w*4 +: 4]);
                for (int q = 0; q < NP; q++)
                    if (m_tid[q] > m_tid[w] && m_bits[q][a] && (best < 0 || m_tid[q] < best))
                        best = m_tid[q];
                if (best >= 0)
                    for (int q = 0; q < NP; q++)
                        if (m_tid[q] >= best) fl[q] = 1'b1;
            end
        end
        if (g && term[o]) begin
            m_act = 0;
            fl = fl | ~(4'b0001 << o);
            for (int p = 0; p < NP; p++)
                for (int s = 0; s < NS; s++) m_bits[p][s] = 0;
        end else begin
            for (int q = 0; q < NP; q++) begin
                if (fl[q] || (g && q == o)) begin
                    for (int s = 0; s < NS; s++) m_bits[q][s] = 0;
                end else if (rd_vld[q]) begin
                    m_bits[q][int'(rd_addr[q*4 +: 4])] = 1;
                end
            end
            if (g && adv[o] && !term[o]) begin
                m_tid[o] += NP;
                m_head++;
            end
        end
        m_flush = fl;
    endtask

    // One clock: grant before the edge, registered results after it
    task automatic step();
        #1;
        if (!rst) check("R3 grant", grant, exp_grant());
        @(posedge clk);
        model_update();
        @(negedge clk);
        check("R2/R10 spec_active", active, m_act);
        check("R7 flush", flush, m_flush);
        for (int p = 0; p < NP; p++)
            check("R4 task_id", tids[p*TW +: TW], m_tid[p] % 256);
    endtask

    task automatic idle();
        start = 0; rd_vld = '0; wr_vld = '0; wr_sync = '0;
        cmt = '0; adv = '0; term = '0;
    endtask

    task automatic do_read(input int p, input int a);
        rd_vld[p] = 1'b1; rd_addr[p*4 +: 4] = 4'(a); step(); idle();
    endtask

    task automatic do_write(input int p, input int a, input bit sync);
        wr_vld[p] = 1'b1; wr_sync[p] = sync; wr_addr[p*4 +: 4] = 4'(a); step(); idle();
    endtask

    task automatic do_adv(input int p);
        adv[p] = 1'b1; step(); idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst = 1; step(); step(); step();
        // R1 reset state
        check("R1 active", active, 0);
        check("R1 flush", flush, 0);
        check("R1 task ids", tids, 0);
        rst = 0;

        // R2 start
        start = 1; step(); idle();
        check("R2 active", active, 1);
        check("R2 ids", tids, 32'h03020100);

        // R3 non-owner request stalls
        cmt[2] = 1; step(); step(); idle();
        // R4 advance by owner 0
        adv[0] = 1; #1 check("R3 owner grant", grant, 4'b0001); step(); idle();
        check("R4 new id", tids[0 +: TW], 4);

        // R6/R7 two younger readers, oldest writer squashes tasks 2..4
        rd_vld = 4'b1100; rd_addr[8 +: 4] = 5; rd_addr[12 +: 4] = 5; step(); idle();
        do_write(1, 5, 0);
        check("R7 squash mask", flush, 4'b1101);
        check("R6 read recorded", flush[2], 1);

        // R7 read by an older task does not squash
        do_read(1, 7);
        do_write(2, 7, 0);
        check("R7 older reader", flush, 0);

        // R8 sync write skipped, then checked write squashes 3 and 4
        do_read(3, 9);
        do_write(1, 9, 1);
        check("R8 sync write", flush, 0);
        do_write(1, 9, 0);
        check("R7 second squash", flush, 4'b1001);
        // R9 flushed bits gone
        do_write(1, 9, 0);
        check("R9 after flush", flush, 0);

        // R7 read in the same cycle as the write is not seen
        rd_vld[3] = 1; rd_addr[12 +: 4] = 2; wr_vld[1] = 1; wr_addr[4 +: 4] = 2; step(); idle();
        check("R7 same cycle", flush, 0);

        // R5 plain commit, with a competing non-owner request (R3)
        cmt = 4'b0110; #1 check("R3 only owner", grant, 4'b0010); step(); idle();
        check("R5 ids unchanged", tids, 32'h03020104);

        // R9 commit clears read bits
        do_read(2, 12);
        do_adv(1);
        do_adv(2);
        do_write(3, 12, 0);
        check("R9 after commit", flush, 0);

        // R10 terminate by owner 3
        term[3] = 1; #1 check("R10 grant", grant, 4'b1000); step(); idle();
        check("R10 inactive", active, 0);
        check("R10 flush others", flush, 4'b0111);
        check("R10 ids kept", tids, 32'h03060504);

        // R13 inactive ignores everything
        do_read(1, 4);
        cmt[0] = 1; #1 check("R13 no grant", grant, 0); step(); idle();
        do_write(0, 4, 0);
        check("R13 no flush", flush, 0);
        check("R13 ids held", tids, 32'h03060504);
        start = 1; step(); idle();
        do_write(0, 4, 0);
        check("R13 read not kept", flush, 0);

        // R2 start while active is ignored
        do_adv(0);
        start = 1; step(); idle();
        check("R2 restart ignored", tids[0 +: TW], 4);

        // R12 run the head up to 254, wrapping the counters
        for (int i = 1; i < 254; i++) do_adv(i % NP);
        do_read(0, 3);
        do_write(3, 3, 0);
        check("R12 wrapped squash", flush, 4'b0011);
        check("R12 wrapped id", tids[0 +: TW], 0);

        // R11 terminate wins over advance
        adv[2] = 1; term[2] = 1; step(); idle();
        check("R11 terminate wins", active, 0);
        check("R11 id kept", tids[16 +: TW], 254);

        step();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule